// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer Pair

Two 8-bit up-counters share one register port. Each counter has a control register, two compare registers (A and B), a status register with three event flags, and three interrupt request outputs. A counter advances on one of several count sources, picked per channel. The sources are three taps of a shared free-running prescaler, an external clock pin counted on its rising edge, its falling edge or both edges, and a cascade input that carries an event from the partner channel.

Cascading works in two ways. The even channel (channel 0) can count the overflows of the odd channel, and the odd channel (channel 1) can count the compare-A events of the even channel. Either way, the pair then works as one 16-bit timer. A counter can return to zero on its own compare A match, on its compare B match, or on a rising edge of its external reset pin. Both external pins pass through a synchronizer before edge detection. Every count request is a single-cycle pulse in the system clock domain.

Top module: `tmr_pair`

## Requirements
- R1: After reset, each channel reads back as follows: control 0x00, status 0x00, counter 0x00, compare A 0xFF and compare B 0xFF. All six interrupt outputs are 0.
- R2: The control byte is laid out as follows. Bits 2:0 hold the count source, bits 4:3 the clear source, bit 5 the overflow interrupt enable, bit 6 the compare-A interrupt enable and bit 7 the compare-B interrupt enable.
- R3: The count source sets how the counter advances. With source 000 the counter does not count. With 001, 010 and 011 the counter advances by one on each falling edge of prescaler bit TAP_FAST, TAP_MID and TAP_SLOW, which by default means every 8, 64 and 8192 system clocks.
- R4: Sources 101, 110 and 111 count the external clock pin. 101 counts its rising edges, 110 its falling edges and 111 both edges.
- R5: Source 100 selects the cascade input. Channel 0 then counts each overflow of channel 1, and channel 1 counts each compare-A event of channel 0.
- R6: If both channels select source 100 at the same time, neither counter advances.
- R7: A compare event occurs when the counter becomes equal to a compare register, and that event sets the matching flag. With clear source 01 (compare A) or 10 (compare B), the counter loads 0 on the next clock instead of counting past the compare value.
- R8: A count pulse that arrives while the counter holds 0xFF wraps the counter to 0x00 and sets the overflow flag.
- R9: With clear source 11, a rising edge on the channel's external reset pin loads 0 into the counter. With any other clear source, that pin has no effect.
- R10: Each interrupt output is high exactly when its flag is set and its enable bit is 1.
- R11: A flag clears when software writes 0 to its bit after reading that bit as 1. A write of 0 with no such read leaves the flag set. If a flag sets in the same cycle that it is cleared, the flag stays set.
- R12: Address bit 3 selects the channel. Address bits 2:0 select the register: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter. Status bit 0 is the overflow flag, bit 1 the compare-A flag and bit 2 the compare-B flag. Writing the counter register loads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address: bit 3 selects the channel, bits 2:0 the register |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms a later flag clear) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| ext_clk_i | input | 2 | External count clock, one pin per channel |
| ext_rst_i | input | 2 | External counter reset, one pin per channel |
| irq_match_a_o | output | 2 | Compare-A interrupt request per channel |
| irq_match_b_o | output | 2 | Compare-B interrupt request per channel |
| irq_wrap_o | output | 2 | Overflow interrupt request per channel |

## Verification
The bench builds the pair with PRE_W=10 and TAP_SLOW=9, which shortens the slowest prescaler tap from 8192 clocks to 1024 clocks. With that setting, counting on every source, a full 0xFF-to-0x00 wrap, and both cascade directions all fit in a short run. The other parameters keep their default values, so the 8- and 64-clock taps and the two-stage pin synchronizer are the same ones the block ships with. The count windows are whole multiples of the tick period, so each expected count is exact whatever the prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    SRC_OFF       = 3'd0,
    SRC_DIV_FAST  = 3'd1,
    SRC_DIV_MID   = 3'd2,
    SRC_DIV_SLOW  = 3'd3,
    SRC_CASCADE   = 3'd4,
    SRC_PIN_RISE  = 3'd5,
    SRC_PIN_FALL  = 3'd6,
    SRC_PIN_BOTH  = 3'd7
  } src_e;

  typedef enum logic [1:0] {
    ZERO_NONE    = 2'd0,
    ZERO_MATCH_A = 2'd1,
    ZERO_MATCH_B = 2'd2,
    ZERO_PIN     = 2'd3
  } zero_e;

  typedef struct packed {
    logic  ie_match_b;
    logic  ie_match_a;
    logic  ie_wrap;
    zero_e zero_sel;
    src_e  src_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CMPA = 3'd2;
  localparam logic [2:0] OFF_CMPB = 3'd3;
  localparam logic [2:0] OFF_CNT  = 3'd4;

  localparam int NUM_FLG     = 3;
  localparam int FLG_WRAP    = 0;
  localparam int FLG_MATCH_A = 1;
  localparam int FLG_MATCH_B = 2;

  localparam int NUM_TAPS = 3;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W    = 13,
  parameter int TAP_FAST = 2,
  parameter int TAP_MID  = 5,
  parameter int TAP_SLOW = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] tick_o
);

  localparam int NTAP = tmr_pkg::NUM_TAPS;

  logic [PRE_W-1:0] pre_q;
  logic [NTAP-1:0]  tap_now;
  logic [NTAP-1:0]  tap_q;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int POS = (g == 0) ? TAP_FAST : (g == 1) ? TAP_MID : TAP_SLOW;
    assign tap_now[g] = pre_q[POS];

    assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[g] |=> !tick_o[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      tap_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      tap_q <= tap_now;
    end
  end

  // falling edge of each tap
  assign tick_o = tap_q & ~tap_now;

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;

  assert_rise_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  assert_fall_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [2:0]       off_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [2:0]       pre_tick_i,
  input  logic             casc_evt_i,
  input  logic             casc_block_i,
  input  logic             clk_rise_i,
  input  logic             clk_fall_i,
  input  logic             rst_rise_i,
  output logic [2:0]       src_o,
  output logic             tick_o,
  output logic             wrap_evt_o,
  output logic             match_a_evt_o,
  output logic             irq_match_a_o,
  output logic             irq_match_b_o,
  output logic             irq_wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   cmpa_q, cmpb_q, cnt_q, cnt_d;
  logic [NUM_FLG-1:0] flag_q, flag_d, armed_q, flag_set, flag_clr;
  logic               eq_a_q, eq_b_q;
  logic               eq_a, eq_b, match_a, match_b, zero_now;
  logic               wr_ctrl, wr_stat, wr_cmpa, wr_cmpb, wr_cnt, rd_stat;
  logic [CTRL_W-1:0]  ctrl_bits;

  assign wr_ctrl = sel_i & wr_en_i & (off_i == OFF_CTRL);
  assign wr_stat = sel_i & wr_en_i & (off_i == OFF_STAT);
  assign wr_cmpa = sel_i & wr_en_i & (off_i == OFF_CMPA);
  assign wr_cmpb = sel_i & wr_en_i & (off_i == OFF_CMPB);
  assign wr_cnt  = sel_i & wr_en_i & (off_i == OFF_CNT);
  assign rd_stat = sel_i & rd_en_i & (off_i == OFF_STAT);

  always_comb begin
    case (ctrl_q.src_sel)
      SRC_DIV_FAST: tick_o = pre_tick_i[0];
      SRC_DIV_MID:  tick_o = pre_tick_i[1];
      SRC_DIV_SLOW: tick_o = pre_tick_i[2];
      SRC_CASCADE:  tick_o = casc_evt_i & ~casc_block_i;
      SRC_PIN_RISE: tick_o = clk_rise_i;
      SRC_PIN_FALL: tick_o = clk_fall_i;
      SRC_PIN_BOTH: tick_o = clk_rise_i | clk_fall_i;
      default:      tick_o = 1'b0;
    endcase
  end

  // match events fire on entry to equality only
  assign eq_a    = (cnt_q == cmpa_q);
  assign eq_b    = (cnt_q == cmpb_q);
  assign match_a = eq_a & ~eq_a_q;
  assign match_b = eq_b & ~eq_b_q;

  always_comb begin
    case (ctrl_q.zero_sel)
      ZERO_MATCH_A: zero_now = match_a;
      ZERO_MATCH_B: zero_now = match_b;
      ZERO_PIN:     zero_now = rst_rise_i;
      default:      zero_now = 1'b0;
    endcase
  end

  assign wrap_evt_o    = tick_o & (cnt_q == CNT_MAX) & ~zero_now & ~wr_cnt;
  assign match_a_evt_o = match_a;

  always_comb begin
    if (wr_cnt)        cnt_d = wdata_i;
    else if (zero_now) cnt_d = '0;
    else if (tick_o)   cnt_d = cnt_q + 1'b1;
    else               cnt_d = cnt_q;
  end

  always_comb begin
    flag_set              = '0;
    flag_set[FLG_WRAP]    = wrap_evt_o;
    flag_set[FLG_MATCH_A] = match_a;
    flag_set[FLG_MATCH_B] = match_b;
  end

  assign flag_clr = {NUM_FLG{wr_stat}} & armed_q & ~wdata_i[NUM_FLG-1:0];
  assign flag_d   = (flag_q & ~flag_clr) | flag_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cmpa_q  <= '1;
      cmpb_q  <= '1;
      cnt_q   <= '0;
      flag_q  <= '0;
      armed_q <= '0;
      eq_a_q  <= 1'b0;
      eq_b_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_cmpa) cmpa_q <= wdata_i;
      if (wr_cmpb) cmpb_q <= wdata_i;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      eq_a_q <= eq_a;
      eq_b_q <= eq_b;
      if (rd_stat)      armed_q <= flag_q;
      else if (wr_stat) armed_q <= '0;
    end
  end

  assign ctrl_bits = ctrl_q;

  always_comb begin
    case (off_i)
      OFF_CTRL: rdata_o = CNT_W'(ctrl_bits);
      OFF_STAT: rdata_o = CNT_W'(flag_q);
      OFF_CMPA: rdata_o = cmpa_q;
      OFF_CMPB: rdata_o = cmpb_q;
      OFF_CNT:  rdata_o = cnt_q;
      default:  rdata_o = '0;
    endcase
  end

  assign src_o         = ctrl_q.src_sel;
  assign irq_match_a_o = flag_q[FLG_MATCH_A] & ctrl_q.ie_match_a;
  assign irq_match_b_o = flag_q[FLG_MATCH_B] & ctrl_q.ie_match_b;
  assign irq_wrap_o    = flag_q[FLG_WRAP]    & ctrl_q.ie_wrap;

  assert_zero_on_match_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.zero_sel == ZERO_MATCH_A && match_a && !wr_cnt) |=> (cnt_q == '0));
  assert_zero_on_match_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.zero_sel == ZERO_MATCH_B && match_b && !wr_cnt) |=> (cnt_q == '0));
  assert_wrap_to_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_evt_o |=> (cnt_q == '0) && flag_q[FLG_WRAP]);
  assert_pin_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.zero_sel == ZERO_PIN && rst_rise_i && !wr_cnt) |=> (cnt_q == '0));
  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_set) |=> ((flag_q & $past(flag_set)) == $past(flag_set)));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 13,
  parameter int TAP_FAST    = 2,
  parameter int TAP_MID     = 5,
  parameter int TAP_SLOW    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [1:0]       ext_clk_i,
  input  logic [1:0]       ext_rst_i,
  output logic [1:0]       irq_match_a_o,
  output logic [1:0]       irq_match_b_o,
  output logic [1:0]       irq_wrap_o
);

  localparam int NUM_CH = 2;
  localparam int CH_BIT = 3;

  logic [2:0]       pre_tick;
  logic [NUM_CH-1:0] clk_rise, clk_fall, rst_rise, rst_fall_unused;
  logic [NUM_CH-1:0] tick, wrap_evt, match_a_evt, casc_evt;
  logic [2:0]       src [NUM_CH];
  logic [CNT_W-1:0] rdata_ch [NUM_CH];
  logic             casc_block;

  tmr_prescaler #(
    .PRE_W    (PRE_W),
    .TAP_FAST (TAP_FAST),
    .TAP_MID  (TAP_MID),
    .TAP_SLOW (TAP_SLOW)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pre_tick)
  );

  // mutual cascade starves both channels
  assign casc_block = (src[0] == SRC_CASCADE) && (src[1] == SRC_CASCADE);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_clk_i[i]),
      .rise_o (clk_rise[i]),
      .fall_o (clk_fall[i])
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_rst_i[i]),
      .rise_o (rst_rise[i]),
      .fall_o (rst_fall_unused[i])
    );

    if (i % 2 == 0) begin : g_even
      assign casc_evt[i] = wrap_evt[i+1];
    end else begin : g_odd
      assign casc_evt[i] = match_a_evt[i-1];
    end

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .sel_i         (addr_i[CH_BIT] == 1'(i)),
      .wr_en_i       (wr_en_i),
      .rd_en_i       (rd_en_i),
      .off_i         (addr_i[2:0]),
      .wdata_i       (wdata_i),
      .rdata_o       (rdata_ch[i]),
      .pre_tick_i    (pre_tick),
      .casc_evt_i    (casc_evt[i]),
      .casc_block_i  (casc_block),
      .clk_rise_i    (clk_rise[i]),
      .clk_fall_i    (clk_fall[i]),
      .rst_rise_i    (rst_rise[i]),
      .src_o         (src[i]),
      .tick_o        (tick[i]),
      .wrap_evt_o    (wrap_evt[i]),
      .match_a_evt_o (match_a_evt[i]),
      .irq_match_a_o (irq_match_a_o[i]),
      .irq_match_b_o (irq_match_b_o[i]),
      .irq_wrap_o    (irq_wrap_o[i])
    );
  end

  assign rdata_o = rdata_ch[addr_i[CH_BIT]];

  assert_no_mutual_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_block |-> (tick == '0));
  assert_even_follows_odd_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src[0] == SRC_CASCADE && !casc_block && wrap_evt[1]) |-> tick[0]);

endmodule

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;

  localparam logic [2:0] O_CTRL = 3'd0;
  localparam logic [2:0] O_STAT = 3'd1;
  localparam logic [2:0] O_CMPA = 3'd2;
  localparam logic [2:0] O_CMPB = 3'd3;
  localparam logic [2:0] O_CNT  = 3'd4;

  // {ctrl[39:32], pin pulses[31:24], window cycles[23:8], expected count[7:0]}
  localparam int NV = 9;
  localparam logic [39:0] VEC [NV] = '{
    {8'h01, 8'd0, 16'd80,   8'd10},   // R3 fast tap
    {8'h01, 8'd0, 16'd2040, 8'd255},  // R3 up to 0xFF
    {8'h02, 8'd0, 16'd640,  8'd10},   // R3 mid tap
    {8'h03, 8'd0, 16'd2048, 8'd2},    // R3 slow tap (1024)
    {8'h05, 8'd7, 16'd0,    8'd7},    // R4 rising
    {8'h06, 8'd5, 16'd0,    8'd5},    // R4 falling
    {8'h07, 8'd6, 16'd0,    8'd12},   // R4 both edges
    {8'h00, 8'd9, 16'd0,    8'd0},    // R3 source off
    {8'h01, 8'd0, 16'd2080, 8'd4}     // R8 wrap past 0xFF
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] ext_clk = '0;
  logic [1:0] ext_rst = '0;
  logic [1:0] irq_a, irq_b, irq_w;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_pair #(.PRE_W(10), .TAP_SLOW(9)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .addr_i        (addr),
    .wr_en_i       (wr_en),
    .rd_en_i       (rd_en),
    .wdata_i       (wdata),
    .rdata_o       (rdata),
    .ext_clk_i     (ext_clk),
    .ext_rst_i     (ext_rst),
    .irq_match_a_o (irq_a),
    .irq_match_b_o (irq_b),
    .irq_wrap_o    (irq_w)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [2:0] off, input logic [7:0] d);
    addr  = {ch, off};
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic ch, input logic [2:0] off, output logic [7:0] d);
    addr  = {ch, off};
    rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pin_pulse(input int ch, input bit is_rst);
    if (is_rst) ext_rst[ch] = 1'b1; else ext_clk[ch] = 1'b1;
    repeat (4) @(negedge clk);
    if (is_rst) ext_rst[ch] = 1'b0; else ext_clk[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic watch_max(input logic ch, input int cycles, output logic [7:0] mx);
    mx   = '0;
    addr = {ch, O_CNT};
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      #1 if (rdata > mx) mx = rdata;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] mx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < 2; ch++) begin
      rd(1'(ch), O_CTRL, d); check("R1 ctrl", d, 8'h00);
      rd(1'(ch), O_STAT, d); check("R1 status", d, 8'h00);
      rd(1'(ch), O_CNT,  d); check("R1 counter", d, 8'h00);
      rd(1'(ch), O_CMPA, d); check("R1 compare A", d, 8'hFF);
      rd(1'(ch), O_CMPB, d); check("R1 compare B", d, 8'hFF);
    end
    check("R1 irqs", {2'b00, irq_a, irq_b, irq_w}, 8'h00);

    // count-source vectors on channel 0
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  vc;
      logic [7:0]  vp;
      logic [15:0] vw;
      vc = VEC[v][39:32];
      vp = VEC[v][31:24];
      vw = VEC[v][23:8];
      wr(1'b0, O_CTRL, vc);
      wr(1'b0, O_CNT, 8'h00);
      if (vw == 0) begin
        for (int p = 0; p < int'(vp); p++) pin_pulse(0, 1'b0);
        repeat (8) @(negedge clk);
      end else begin
        repeat (int'(vw) - 1) @(negedge clk);
      end
      wr(1'b0, O_CTRL, 8'h00);
      rd(1'b0, O_CNT, d);
      check($sformatf("R3/R4/R8 vector %0d", v), d, VEC[v][7:0]);
    end

    // R10 enables gate the flags left by the wrap vector
    wr(1'b0, O_CTRL, 8'hE0);
    check("R10 irqs enabled", {2'b00, irq_a, irq_b, irq_w}, 8'b0001_0101);
    wr(1'b0, O_CTRL, 8'h00);
    check("R10 irqs masked", {2'b00, irq_a, irq_b, irq_w}, 8'h00);

    // R11 clear protocol
    wr(1'b0, O_STAT, 8'h00);
    rd(1'b0, O_STAT, d); check("R11 write without read", d, 8'h07);
    wr(1'b0, O_STAT, 8'h06);
    rd(1'b0, O_STAT, d); check("R11 clear wrap flag only", d, 8'h06);
    wr(1'b0, O_STAT, 8'h00);
    rd(1'b0, O_STAT, d); check("R11 clear remaining", d, 8'h00);

    // R7 clear on compare A
    wr(1'b0, O_CMPA, 8'd9);
    wr(1'b0, O_CNT, 8'h00);
    wr(1'b0, O_CTRL, 8'h49);
    watch_max(1'b0, 300, mx);
    check("R7 max with clear on A", mx, 8'd9);
    check("R10 compare A irq", {7'b0, irq_a[0]}, 8'h01);
    wr(1'b0, O_CTRL, 8'h00);
    rd(1'b0, O_STAT, d); check("R7 compare A flag", d & 8'h02, 8'h02);
    wr(1'b0, O_STAT, 8'h00);

    // R7 clear on compare B, enable off
    wr(1'b0, O_CMPB, 8'd5);
    wr(1'b0, O_CNT, 8'h00);
    wr(1'b0, O_CTRL, 8'h11);
    watch_max(1'b0, 200, mx);
    check("R7 max with clear on B", mx, 8'd5);
    check("R10 compare B irq masked", {7'b0, irq_b[0]}, 8'h00);
    wr(1'b0, O_CTRL, 8'h00);
    rd(1'b0, O_STAT, d); check("R7 compare B flag", d & 8'h04, 8'h04);

    // R9 external reset pin
    wr(1'b0, O_CTRL, 8'h18);
    wr(1'b0, O_CNT, 8'h55);
    pin_pulse(0, 1'b1);
    rd(1'b0, O_CNT, d); check("R9 pin clears", d, 8'h00);
    wr(1'b0, O_CTRL, 8'h00);
    wr(1'b0, O_CNT, 8'h55);
    pin_pulse(0, 1'b1);
    rd(1'b0, O_CNT, d); check("R9 pin ignored", d, 8'h55);

    // R5 even channel counts odd wraps
    wr(1'b0, O_CNT, 8'h00);
    wr(1'b1, O_CNT, 8'hFE);
    wr(1'b0, O_CTRL, 8'h04);
    wr(1'b1, O_CTRL, 8'h01);
    repeat (31) @(negedge clk);
    wr(1'b1, O_CTRL, 8'h00);
    rd(1'b1, O_CNT, d); check("R5 odd low byte", d, 8'h02);
    rd(1'b0, O_CNT, d); check("R5 even high byte", d, 8'h01);

    // R5 odd channel counts even compare-A events
    wr(1'b0, O_CTRL, 8'h00);
    wr(1'b0, O_CNT, 8'h00);
    wr(1'b1, O_CNT, 8'h00);
    wr(1'b1, O_CTRL, 8'h04);
    wr(1'b0, O_CMPA, 8'd3);
    wr(1'b0, O_CTRL, 8'h01);
    repeat (39) @(negedge clk);
    wr(1'b0, O_CTRL, 8'h00);
    rd(1'b0, O_CNT, d); check("R5 even counter", d, 8'd5);
    rd(1'b1, O_CNT, d); check("R5 odd counts match A", d, 8'd1);

    // R6 mutual cascade produces no count
    wr(1'b0, O_CTRL, 8'h04);
    wr(1'b1, O_CNT, 8'hFF);
    wr(1'b0, O_CNT, 8'd3);
    repeat (20) @(negedge clk);
    rd(1'b0, O_CNT, d); check("R6 even held", d, 8'd3);
    rd(1'b1, O_CNT, d); check("R6 odd held", d, 8'hFF);
    wr(1'b0, O_CTRL, 8'h00);
    wr(1'b1, O_CTRL, 8'h00);

    // R12 channel select and register offsets
    wr(1'b1, O_CMPB, 8'h3C);
    rd(1'b1, O_CMPB, d); check("R12 odd compare B", d, 8'h3C);
    rd(1'b0, O_CMPB, d); check("R12 even compare B untouched", d, 8'd5);
    wr(1'b1, O_CTRL, 8'hA6);
    rd(1'b1, O_CTRL, d); check("R2 control readback", d, 8'hA6);
    wr(1'b1, O_CTRL, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule